// File: doc/BRIEF.md
# Multi-Port Memory Command Merger

This block sits between several client ports and a single memory controller command channel. Each client port has three queues. The command queue holds an address, a 3-bit opcode and a burst count. The write queue holds data words, each with a per-byte enable mask. The return queue holds read words on their way back to the client. A round-robin arbiter picks one port at a time and loads its oldest command into a registered output slot. If the command is a write, the block then streams that port's write words out on consecutive cycles. Interleaving between ports depends on arbitration, but each port's own commands leave in the order they were queued.

Read data comes back from the controller in the order the reads were issued. A small queue of tags records the port and burst count of every granted read. Each returning word is pushed into the return queue of the port at the head of that tag queue. A read is only granted when the target return queue has room for it, so returned words never need to be dropped. All ports share one clock.

Top module: `mem_cmd_merger`

## Requirements
- R1: After a synchronous active-high reset, `mc_cmd_valid` and `mc_wd_valid` are low, every `cmd_full`, `wd_full` and `rd_avail` is low, and the round-robin search starts at port 0.
- R2: Among eligible ports, the grant goes to the first one found when searching from the port after the last granted port, wrapping around. Ports that are not eligible are skipped in the same cycle. At most one port is granted per cycle.
- R3: The commands of one port appear on the output in the order they were pushed, with address, opcode and burst field unchanged, and `mc_cmd_port` gives the port number.
- R4: The burst field b means b+1 data words. A write is eligible only when its port's write queue holds at least b+1 words. A read is eligible only when the tag queue is not full.
- R5: A granted write puts b+1 words of that port's write queue on `mc_wd_data`/`mc_wd_mask`, in push order, on consecutive cycles. The first word comes one cycle after the command appears. No new grant is made until the last word has been taken from the queue.
- R6: Each word on `mc_rd_data` with `mc_rd_valid` high goes into the return queue of the oldest granted read that is still incomplete. After b+1 words, the next granted read becomes the target.
- R7: A read is eligible only when the port's return-queue occupancy, plus the words still owed to that port, plus b+1, does not exceed the return-queue depth.
- R8: While `mc_cmd_valid` is high and `mc_cmd_ready` is low, the command outputs hold their values. A new grant loads only when the slot is empty or being accepted.
- R9: `cmd_full` is high when the command queue holds its depth. `wd_full` is high when the write queue holds its depth. A push into a full queue is ignored, and a pop of an empty return queue is ignored.
- R10: Opcodes are 3'b000 write, 3'b001 read, 3'b010 write with auto-precharge and 3'b011 read with auto-precharge. Bit 0 set marks a read. The opcode is passed to the output unchanged.
- R11: A `mc_rd_valid` word that arrives when no granted read is outstanding is ignored. No return queue changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by all ports |
| rst | input | 1 | Synchronous active-high reset |
| cmd_push | input | NPORTS | Per-port command push strobe |
| cmd_addr | input | NPORTS*ADDR_W | Per-port command address |
| cmd_op | input | NPORTS*3 | Per-port opcode |
| cmd_bl | input | NPORTS*BL_W | Per-port burst field (words minus one) |
| cmd_full | output | NPORTS | Per-port command queue full |
| wd_push | input | NPORTS | Per-port write-word push strobe |
| wd_data | input | NPORTS*DATA_W | Per-port write data |
| wd_mask | input | NPORTS*DATA_W/8 | Per-port byte enables |
| wd_full | output | NPORTS | Per-port write queue full |
| rd_pop | input | NPORTS | Per-port return-word pop strobe |
| rd_data | output | NPORTS*DATA_W | Head word of each return queue |
| rd_avail | output | NPORTS | Return queue not empty |
| mc_cmd_valid | output | 1 | Command slot holds a command |
| mc_cmd_ready | input | 1 | Controller takes the command |
| mc_cmd_op | output | 3 | Issued opcode |
| mc_cmd_addr | output | ADDR_W | Issued address |
| mc_cmd_bl | output | BL_W | Issued burst field |
| mc_cmd_port | output | $clog2(NPORTS) | Port that owns the issued command |
| mc_wd_valid | output | 1 | Write word valid |
| mc_wd_data | output | DATA_W | Write word |
| mc_wd_mask | output | DATA_W/8 | Byte enables of the write word |
| mc_rd_valid | input | 1 | Read word returned by the controller |
| mc_rd_data | input | DATA_W | Returned read word |

## Verification
The bench targets several corner cases, each with a known failure symptom:
- A write queued before its data is complete must stay held back. A design that skips the data-count check would issue it and then stream stale words.
- A read toward a nearly full return queue must wait. A design that forgets in-flight words would overrun the queue and lose data.
- Simultaneous requests from all ports, and requests from alternate ports only, expose a pointer that does not skip idle ports or that does not advance past the winner.
- A stalled command slot, stray read returns and pushes into full queues catch designs that change held outputs, steer orphan words somewhere, or accept writes beyond capacity.

// File: rtl/mcm_pkg.sv
package mcm_pkg;
  localparam logic [2:0] OP_WR   = 3'b000;
  localparam logic [2:0] OP_RD   = 3'b001;
  localparam logic [2:0] OP_WRAP = 3'b010;
  localparam logic [2:0] OP_RDAP = 3'b011;

  // bit 0 distinguishes the read class from the write class
  function automatic logic op_is_read(input logic [2:0] op);
    return op[0];
  endfunction
endpackage

// File: rtl/mcm_fifo.sv
module mcm_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         push,
  input  logic [W-1:0]                 din,
  input  logic                         pop,
  output logic [W-1:0]                 dout,
  output logic [$clog2(DEPTH+1)-1:0]   count
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH+1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic          do_push, do_pop;

  assign do_push = push && (count != CW'(DEPTH));
  assign do_pop  = pop && (count != '0);

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (do_push) wp <= wp + 1'b1;
      if (do_pop)  rp <= rp + 1'b1;
      count <= count + CW'(do_push) - CW'(do_pop);
    end
  end

  assign dout = mem[rp];

  // R9
  occupancy_chk: assert property (@(posedge clk) disable iff (rst)
    count <= CW'(DEPTH));
endmodule

// File: rtl/mcm_rr_arb.sv
module mcm_rr_arb #(
  parameter int N = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [N-1:0]          req,
  input  logic                  adv,
  output logic [N-1:0]          gnt,
  output logic [$clog2(N)-1:0]  gidx
);
  localparam int IW = $clog2(N);

  logic [IW-1:0] ptr;

  // scan from far to near so the nearest requester after ptr wins
  always_comb begin
    gnt  = '0;
    gidx = '0;
    for (int k = N - 1; k >= 0; k--) begin
      automatic int j = (int'(ptr) + k) % N;
      if (req[j]) begin
        gnt    = '0;
        gnt[j] = 1'b1;
        gidx   = IW'(j);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) ptr <= '0;
    else if (adv) ptr <= (gidx == IW'(N - 1)) ? '0 : gidx + 1'b1;
  end

  // R2
  onehot_grant_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(gnt));
endmodule

// File: rtl/mem_cmd_merger.sv
module mem_cmd_merger #(
  parameter int NPORTS      = 4,
  parameter int ADDR_W      = 28,
  parameter int DATA_W      = 32,
  parameter int BL_W        = 3,
  parameter int CMDQ_DEPTH  = 4,
  parameter int DATAQ_DEPTH = 128,
  parameter int TAGQ_DEPTH  = 4
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [NPORTS-1:0]             cmd_push,
  input  logic [NPORTS*ADDR_W-1:0]      cmd_addr,
  input  logic [NPORTS*3-1:0]           cmd_op,
  input  logic [NPORTS*BL_W-1:0]        cmd_bl,
  output logic [NPORTS-1:0]             cmd_full,
  input  logic [NPORTS-1:0]             wd_push,
  input  logic [NPORTS*DATA_W-1:0]      wd_data,
  input  logic [NPORTS*DATA_W/8-1:0]    wd_mask,
  output logic [NPORTS-1:0]             wd_full,
  input  logic [NPORTS-1:0]             rd_pop,
  output logic [NPORTS*DATA_W-1:0]      rd_data,
  output logic [NPORTS-1:0]             rd_avail,
  output logic                          mc_cmd_valid,
  input  logic                          mc_cmd_ready,
  output logic [2:0]                    mc_cmd_op,
  output logic [ADDR_W-1:0]             mc_cmd_addr,
  output logic [BL_W-1:0]               mc_cmd_bl,
  output logic [$clog2(NPORTS)-1:0]     mc_cmd_port,
  output logic                          mc_wd_valid,
  output logic [DATA_W-1:0]             mc_wd_data,
  output logic [DATA_W/8-1:0]           mc_wd_mask,
  input  logic                          mc_rd_valid,
  input  logic [DATA_W-1:0]             mc_rd_data
);
  import mcm_pkg::*;

  localparam int MASK_W = DATA_W / 8;
  localparam int PID_W  = $clog2(NPORTS);
  localparam int CMD_W  = 3 + ADDR_W + BL_W;
  localparam int WD_W   = DATA_W + MASK_W;
  localparam int TAG_W  = PID_W + BL_W;
  localparam int CQC_W  = $clog2(CMDQ_DEPTH + 1);
  localparam int DQC_W  = $clog2(DATAQ_DEPTH + 1);
  localparam int TQC_W  = $clog2(TAGQ_DEPTH + 1);
  localparam int SUM_W  = DQC_W + 2;

  logic [CMD_W-1:0]  cq_head [NPORTS];
  logic [CQC_W-1:0]  cq_cnt  [NPORTS];
  logic [WD_W-1:0]   wq_head [NPORTS];
  logic [DQC_W-1:0]  wq_cnt  [NPORTS];
  logic [DQC_W-1:0]  rq_cnt  [NPORTS];
  logic [NPORTS-1:0] elig, req, gnt, wq_pop, rd_push;
  logic [PID_W-1:0]  gidx;
  logic              grant, can_issue;
  logic [CMD_W-1:0]  sel;
  logic              sel_rd;
  logic [BL_W:0]     sel_words;
  logic [BL_W:0]     wcnt;
  logic [PID_W-1:0]  wport;
  logic [BL_W-1:0]   rcnt;
  logic [TAG_W-1:0]  tag_head;
  logic [TQC_W-1:0]  tag_cnt;
  logic              ret_ok, tag_done;

  // ---------------- per-port queues and eligibility ----------------
  for (genvar p = 0; p < NPORTS; p++) begin : g_port
    logic [2:0]       h_op;
    logic [BL_W:0]    h_words;
    logic [SUM_W-1:0] room_need;
    logic [DQC_W-1:0] infl_q;   // read words granted but not yet returned

    assign h_op      = cq_head[p][CMD_W-1 -: 3];
    assign h_words   = {1'b0, cq_head[p][BL_W-1:0]} + 1'b1;
    assign room_need = SUM_W'(rq_cnt[p]) + SUM_W'(infl_q) + SUM_W'(h_words);
    assign elig[p]   = (cq_cnt[p] != '0) &&
                       (op_is_read(h_op)
                          ? ((tag_cnt != TQC_W'(TAGQ_DEPTH)) && (room_need <= SUM_W'(DATAQ_DEPTH)))
                          : (SUM_W'(wq_cnt[p]) >= SUM_W'(h_words)));

    assign wq_pop[p]  = (wcnt != '0) && (wport == PID_W'(p));
    assign rd_push[p] = ret_ok && (tag_head[TAG_W-1 -: PID_W] == PID_W'(p));

    mcm_fifo #(.W(CMD_W), .DEPTH(CMDQ_DEPTH)) u_cq (
      .clk(clk), .rst(rst), .push(cmd_push[p]),
      .din({cmd_op[p*3 +: 3], cmd_addr[p*ADDR_W +: ADDR_W], cmd_bl[p*BL_W +: BL_W]}),
      .pop(gnt[p]), .dout(cq_head[p]), .count(cq_cnt[p]));

    mcm_fifo #(.W(WD_W), .DEPTH(DATAQ_DEPTH)) u_wq (
      .clk(clk), .rst(rst), .push(wd_push[p]),
      .din({wd_mask[p*MASK_W +: MASK_W], wd_data[p*DATA_W +: DATA_W]}),
      .pop(wq_pop[p]), .dout(wq_head[p]), .count(wq_cnt[p]));

    mcm_fifo #(.W(DATA_W), .DEPTH(DATAQ_DEPTH)) u_rq (
      .clk(clk), .rst(rst), .push(rd_push[p]), .din(mc_rd_data),
      .pop(rd_pop[p]), .dout(rd_data[p*DATA_W +: DATA_W]), .count(rq_cnt[p]));

    assign cmd_full[p] = (cq_cnt[p] == CQC_W'(CMDQ_DEPTH));
    assign wd_full[p]  = (wq_cnt[p] == DQC_W'(DATAQ_DEPTH));
    assign rd_avail[p] = (rq_cnt[p] != '0);

    always_ff @(posedge clk) begin
      if (rst) infl_q <= '0;
      else infl_q <= infl_q
                   + ((grant && sel_rd && (gidx == PID_W'(p))) ? DQC_W'(sel_words) : '0)
                   - DQC_W'(rd_push[p]);
    end

    // R7
    rdq_room_chk: assert property (@(posedge clk) disable iff (rst)
      rd_push[p] |-> (rq_cnt[p] != DQC_W'(DATAQ_DEPTH)));
  end

  // ---------------- arbitration ----------------
  assign can_issue = (!mc_cmd_valid || mc_cmd_ready) && (wcnt == '0);
  assign req       = can_issue ? elig : '0;
  assign grant     = |req;

  mcm_rr_arb #(.N(NPORTS)) u_arb (
    .clk(clk), .rst(rst), .req(req), .adv(grant), .gnt(gnt), .gidx(gidx));

  assign sel       = cq_head[gidx];
  assign sel_rd    = op_is_read(sel[CMD_W-1 -: 3]);
  assign sel_words = {1'b0, sel[BL_W-1:0]} + 1'b1;

  // ---------------- command output slot ----------------
  always_ff @(posedge clk) begin
    if (rst) begin
      mc_cmd_valid <= 1'b0;
      mc_cmd_op    <= '0;
      mc_cmd_addr  <= '0;
      mc_cmd_bl    <= '0;
      mc_cmd_port  <= '0;
    end else if (grant) begin
      mc_cmd_valid                       <= 1'b1;
      {mc_cmd_op, mc_cmd_addr, mc_cmd_bl} <= sel;
      mc_cmd_port                        <= gidx;
    end else if (mc_cmd_ready) begin
      mc_cmd_valid <= 1'b0;
    end
  end

  // ---------------- write burst streaming ----------------
  always_ff @(posedge clk) begin
    if (rst) begin
      wcnt        <= '0;
      wport       <= '0;
      mc_wd_valid <= 1'b0;
      mc_wd_data  <= '0;
      mc_wd_mask  <= '0;
    end else begin
      mc_wd_valid <= (wcnt != '0);
      if (wcnt != '0) {mc_wd_mask, mc_wd_data} <= wq_head[wport];
      if (grant && !sel_rd) begin
        wcnt  <= sel_words;
        wport <= gidx;
      end else if (wcnt != '0) begin
        wcnt <= wcnt - 1'b1;
      end
    end
  end

  // ---------------- read return steering ----------------
  mcm_fifo #(.W(TAG_W), .DEPTH(TAGQ_DEPTH)) u_tq (
    .clk(clk), .rst(rst), .push(grant && sel_rd), .din({gidx, sel[BL_W-1:0]}),
    .pop(tag_done), .dout(tag_head), .count(tag_cnt));

  assign ret_ok   = mc_rd_valid && (tag_cnt != '0);
  assign tag_done = ret_ok && (rcnt == tag_head[BL_W-1:0]);

  always_ff @(posedge clk) begin
    if (rst)           rcnt <= '0;
    else if (tag_done) rcnt <= '0;
    else if (ret_ok)   rcnt <= rcnt + 1'b1;
  end

  // R8
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (mc_cmd_valid && !mc_cmd_ready) |=>
      (mc_cmd_valid && $stable({mc_cmd_op, mc_cmd_addr, mc_cmd_bl, mc_cmd_port})));

  // R5
  burst_follows_write_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(mc_wd_valid) |-> ($past(mc_cmd_valid) && !$past(mc_cmd_op[0])));

  // R5
  drain_block_chk: assert property (@(posedge clk) disable iff (rst)
    (wcnt != '0) |-> (gnt == '0));
endmodule

// File: tb/sim_mem_cmd_merger.sv
module sim_mem_cmd_merger;
  localparam int CLK_PERIOD = 10;
  localparam int N   = 4;
  localparam int AW  = 16;
  localparam int DW  = 32;
  localparam int MW  = DW / 8;
  localparam int BLW = 3;
  localparam int CQD = 4;
  localparam int DQD = 16;
  localparam int TQD = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [N-1:0]      cmd_push, cmd_full, wd_push, wd_full, rd_pop, rd_avail;
  logic [N*AW-1:0]   cmd_addr;
  logic [N*3-1:0]    cmd_op;
  logic [N*BLW-1:0]  cmd_bl;
  logic [N*DW-1:0]   wd_data, rd_data;
  logic [N*MW-1:0]   wd_mask;
  logic              mc_cmd_valid, mc_cmd_ready;
  logic [2:0]        mc_cmd_op;
  logic [AW-1:0]     mc_cmd_addr;
  logic [BLW-1:0]    mc_cmd_bl;
  logic [1:0]        mc_cmd_port;
  logic              mc_wd_valid;
  logic [DW-1:0]     mc_wd_data;
  logic [MW-1:0]     mc_wd_mask;
  logic              mc_rd_valid;
  logic [DW-1:0]     mc_rd_data;

  mem_cmd_merger #(.NPORTS(N), .ADDR_W(AW), .DATA_W(DW), .BL_W(BLW),
                   .CMDQ_DEPTH(CQD), .DATAQ_DEPTH(DQD), .TAGQ_DEPTH(TQD)) u0 (
    .clk(clk), .rst(rst),
    .cmd_push(cmd_push), .cmd_addr(cmd_addr), .cmd_op(cmd_op), .cmd_bl(cmd_bl), .cmd_full(cmd_full),
    .wd_push(wd_push), .wd_data(wd_data), .wd_mask(wd_mask), .wd_full(wd_full),
    .rd_pop(rd_pop), .rd_data(rd_data), .rd_avail(rd_avail),
    .mc_cmd_valid(mc_cmd_valid), .mc_cmd_ready(mc_cmd_ready), .mc_cmd_op(mc_cmd_op),
    .mc_cmd_addr(mc_cmd_addr), .mc_cmd_bl(mc_cmd_bl), .mc_cmd_port(mc_cmd_port),
    .mc_wd_valid(mc_wd_valid), .mc_wd_data(mc_wd_data), .mc_wd_mask(mc_wd_mask),
    .mc_rd_valid(mc_rd_valid), .mc_rd_data(mc_rd_data));

  // ---------------- reference model state ----------------
  typedef struct packed {
    logic [2:0]     op;
    logic [AW-1:0]  addr;
    logic [BLW-1:0] bl;
  } mcmd_t;

  mcmd_t              mq_c [N][$];
  logic [MW+DW-1:0]   mq_w [N][$];
  logic [DW-1:0]      mq_r [N][$];
  int                 tq_p [$];
  int                 tq_b [$];
  int                 infl [N];
  int                 wneed [N];
  int                 ptr = 0, wcnt = 0, wport = 0, rcnt = 0;
  bit                 e_cv = 0, e_wv = 0;
  mcmd_t              e_cmd = '0;
  int                 e_port = 0;
  logic [MW+DW-1:0]   e_wd = '0;

  int    checks = 0, fails = 0;
  string tag = "R1";
  int    rd_mode = 0;
  logic [DW-1:0] rd_pat = 32'hA000_0000;

  task automatic chk(input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic int owed();
    int s = 0;
    foreach (tq_b[i]) s += tq_b[i] + 1;
    return s - rcnt;
  endfunction

  // one clock edge of the model, using the inputs currently driven
  task automatic m_step();
    bit [N-1:0] el;
    bit cfull [N];
    bit wfull [N];
    bit rempty [N];
    bit can, found;
    int g;
    mcmd_t h;
    can = (!e_cv || mc_cmd_ready) && (wcnt == 0);
    found = 0; g = 0;
    for (int p = 0; p < N; p++) begin
      cfull[p]  = (mq_c[p].size() == CQD);
      wfull[p]  = (mq_w[p].size() == DQD);
      rempty[p] = (mq_r[p].size() == 0);
      el[p] = 0;
      if (can && mq_c[p].size() > 0) begin
        h = mq_c[p][0];
        if (h.op[0]) el[p] = (tq_p.size() < TQD) && (mq_r[p].size() + infl[p] + int'(h.bl) + 1 <= DQD);
        else         el[p] = (mq_w[p].size() >= int'(h.bl) + 1);
      end
    end
    for (int k = 0; k < N; k++) begin
      int j = (ptr + k) % N;
      if (!found && el[j]) begin found = 1; g = j; end
    end
    if (wcnt != 0) begin
      e_wv = 1; e_wd = mq_w[wport].pop_front(); wcnt--;
    end else e_wv = 0;
    if (mc_rd_valid && tq_p.size() > 0) begin
      int q = tq_p[0];
      mq_r[q].push_back(mc_rd_data);
      infl[q]--;
      if (rcnt == tq_b[0]) begin
        void'(tq_p.pop_front()); void'(tq_b.pop_front()); rcnt = 0;
      end else rcnt++;
    end
    if (found) begin
      h = mq_c[g].pop_front();
      e_cv = 1; e_cmd = h; e_port = g; ptr = (g + 1) % N;
      if (h.op[0]) begin
        tq_p.push_back(g); tq_b.push_back(int'(h.bl)); infl[g] += int'(h.bl) + 1;
      end else begin
        wcnt = int'(h.bl) + 1; wport = g;
      end
    end else if (mc_cmd_ready) e_cv = 0;
    for (int p = 0; p < N; p++) begin
      if (cmd_push[p] && !cfull[p])
        mq_c[p].push_back({cmd_op[p*3 +: 3], cmd_addr[p*AW +: AW], cmd_bl[p*BLW +: BLW]});
      if (wd_push[p] && !wfull[p])
        mq_w[p].push_back({wd_mask[p*MW +: MW], wd_data[p*DW +: DW]});
      if (rd_pop[p] && !rempty[p]) void'(mq_r[p].pop_front());
    end
  endtask

  task automatic compare();
    chk("cmd valid", 64'(mc_cmd_valid), 64'(e_cv));
    if (e_cv) begin
      chk("cmd op",   64'(mc_cmd_op),   64'(e_cmd.op));
      chk("cmd addr", 64'(mc_cmd_addr), 64'(e_cmd.addr));
      chk("cmd bl",   64'(mc_cmd_bl),   64'(e_cmd.bl));
      chk("cmd port", 64'(mc_cmd_port), 64'(e_port));
    end
    chk("wd valid", 64'(mc_wd_valid), 64'(e_wv));
    if (e_wv) chk("wd word", 64'({mc_wd_mask, mc_wd_data}), 64'(e_wd));
    for (int p = 0; p < N; p++) begin
      chk("cmd full", 64'(cmd_full[p]), 64'(mq_c[p].size() == CQD));
      chk("wd full",  64'(wd_full[p]),  64'(mq_w[p].size() == DQD));
      chk("rd avail", 64'(rd_avail[p]), 64'(mq_r[p].size() > 0));
      if (mq_r[p].size() > 0) chk("rd data", 64'(rd_data[p*DW +: DW]), 64'(mq_r[p][0]));
    end
  endtask

  task automatic step();
    if (rd_mode == 1)      mc_rd_valid = (owed() > 0) && ($urandom_range(3) != 0);
    else if (rd_mode == 0) mc_rd_valid = 1'b0;
    mc_rd_data = rd_pat;
    if (mc_rd_valid) rd_pat = rd_pat + 32'h0101_0011;
    m_step();
    @(posedge clk);
    @(negedge clk);
    compare();
    cmd_push = '0; wd_push = '0; rd_pop = '0;
  endtask

  task automatic set_cmd(input int p, input logic [2:0] op, input logic [AW-1:0] a, input logic [BLW-1:0] bl);
    cmd_push[p] = 1'b1;
    cmd_op[p*3 +: 3] = op;
    cmd_addr[p*AW +: AW] = a;
    cmd_bl[p*BLW +: BLW] = bl;
  endtask

  task automatic set_wd(input int p);
    wd_push[p] = 1'b1;
    wd_data[p*DW +: DW] = $urandom;
    wd_mask[p*MW +: MW] = MW'($urandom);
  endtask

  task automatic run(input int n);
    repeat (n) step();
  endtask

  // pops every non-empty return queue while stepping; feeds owed write words
  task automatic drain(input int n);
    repeat (n) begin
      for (int p = 0; p < N; p++) begin
        rd_pop[p] = (mq_r[p].size() > 0);
        if (wneed[p] > 0 && mq_w[p].size() < DQD) begin set_wd(p); wneed[p]--; end
      end
      step();
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    cmd_push = '0; cmd_addr = '0; cmd_op = '0; cmd_bl = '0;
    wd_push = '0; wd_data = '0; wd_mask = '0; rd_pop = '0;
    mc_cmd_ready = 1'b1; mc_rd_valid = 1'b0; mc_rd_data = '0;
    for (int p = 0; p < N; p++) begin infl[p] = 0; wneed[p] = 0; end
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1: reset state seen at the ports
    tag = "R1";
    compare();
    run(2);

    // R3: in-order issue from one port, writes and reads mixed
    tag = "R3"; rd_mode = 1;
    for (int i = 0; i < 5; i++) begin set_wd(0); step(); end
    set_cmd(0, 3'b000, 16'h0010, 3'd3); step();
    set_cmd(0, 3'b001, 16'h0010, 3'd1); step();
    set_cmd(0, 3'b000, 16'h0020, 3'd0); step();
    set_cmd(0, 3'b001, 16'h0020, 3'd0); step();
    drain(30);

    // R10: auto-precharge opcodes pass through and are classed by bit 0
    tag = "R10";
    set_wd(1); step(); set_wd(1); step();
    set_cmd(1, 3'b010, 16'h0300, 3'd1); step();
    set_cmd(1, 3'b011, 16'h0300, 3'd2); step();
    drain(30);

    // R2: all ports request together, then only ports 1 and 3
    tag = "R2";
    for (int p = 0; p < N; p++) set_cmd(p, 3'b001, AW'(16'h0400 + p), 3'd0);
    step();
    for (int p = 0; p < N; p++) set_cmd(p, 3'b001, AW'(16'h0500 + p), 3'd0);
    step();
    drain(30);
    set_cmd(1, 3'b001, 16'h0601, 3'd0); set_cmd(3, 3'b001, 16'h0603, 3'd0); step();
    set_cmd(1, 3'b001, 16'h0611, 3'd0); set_cmd(3, 3'b001, 16'h0613, 3'd0); step();
    drain(20);

    // R4: write held until its data is complete
    tag = "R4";
    set_wd(2); step(); set_wd(2); step();
    set_cmd(2, 3'b000, 16'h0700, 3'd3); step();
    run(10);
    set_wd(2); step(); set_wd(2); step();
    drain(20);

    // R8: stalled command slot
    tag = "R8";
    mc_cmd_ready = 1'b0;
    set_cmd(0, 3'b001, 16'h0800, 3'd0); set_cmd(1, 3'b001, 16'h0801, 3'd0); step();
    run(6);
    mc_cmd_ready = 1'b1;
    drain(20);

    // R7: return-queue room including in-flight words
    tag = "R7";
    for (int i = 0; i < 3; i++) begin set_cmd(1, 3'b001, AW'(16'h0900 + i), 3'd7); step(); end
    run(40);
    drain(60);

    // R6: reads from several ports with gaps in the return stream
    tag = "R6";
    for (int c = 0; c < 200; c++) begin
      for (int p = 0; p < N; p++) begin
        if (p != 1 && $urandom_range(3) == 0 && mq_c[p].size() < CQD)
          set_cmd(p, ($urandom_range(1) == 1) ? 3'b001 : 3'b011, AW'($urandom), BLW'($urandom));
        rd_pop[p] = ($urandom_range(2) == 0);
      end
      step();
    end
    drain(120);

    // R9: full flags and ignored pushes
    tag = "R9";
    mc_cmd_ready = 1'b0;
    for (int i = 0; i < 7; i++) begin set_cmd(3, 3'b001, AW'(16'h0A00 + i), 3'd0); step(); end
    for (int i = 0; i < DQD + 4; i++) begin set_wd(0); step(); end
    mc_cmd_ready = 1'b1;
    set_cmd(0, 3'b000, 16'h0B00, 3'd7); step();
    set_cmd(0, 3'b000, 16'h0B08, 3'd7); step();
    drain(80);

    // R11: stray returns with nothing outstanding
    tag = "R11";
    rd_mode = 2;
    for (int i = 0; i < 3; i++) begin mc_rd_valid = (owed() == 0); step(); end
    mc_rd_valid = 1'b0;
    rd_mode = 1;
    run(3);

    // R5: mixed traffic with write bursts and backpressure
    tag = "R5";
    for (int c = 0; c < 3000; c++) begin
      for (int p = 0; p < N; p++) begin
        if ($urandom_range(7) == 0 && mq_c[p].size() < CQD) begin
          logic [2:0]     op = 3'($urandom_range(3));
          logic [BLW-1:0] bl = BLW'($urandom);
          set_cmd(p, op, AW'($urandom), bl);
          if (!op[0]) wneed[p] += int'(bl) + 1;
        end
        if (wneed[p] > 0 && mq_w[p].size() < DQD && $urandom_range(1) == 1) begin
          set_wd(p); wneed[p]--;
        end
        rd_pop[p] = ($urandom_range(1) == 1);
      end
      mc_cmd_ready = ($urandom_range(3) != 0);
      step();
    end
    mc_cmd_ready = 1'b1;
    drain(400);

    summary();
    $finish;
  end
endmodule